// File: doc/BRIEF.md
# Encoder Transaction Sequencer

This block runs one complete exchange with a serial position encoder from start to finish. It starts a transaction either when the host raises a trigger bit or, in periodic mode, when its own period counter reaches a compare value. It decodes the command code to find how many memory frames the transmitter has to append and how many reply frames the receiver should expect. It then starts the transmitter, waits for it to finish, and arms the receiver with the expected frame count. When the receiver reports the outcome, the block records the result and raises a completion flag.

Reset-class commands only take effect after several identical transmissions in a row. The sequencer sends them a fixed number of times within one transaction, with no help from the host. In periodic mode the same command is issued again every period. If a period event arrives while a transaction is still running, it is counted as an overrun and no transaction is started for it. A framing error or a receiver that stays silent too long ends the transaction with a fault status instead of a CRC result.

Top module: `enc_txn_seq`

## Requirements
- R1: After reset: busy_o=0, done_o=0, status_o=2'b00, rep_cnt_o=0, ovr_cnt_o=0, tx_start_o=0, rx_arm_o=0.
- R2: In host mode (mode_periodic_i=0), host_trig_i high while idle puts tx_start_o high on the next cycle, with tx_cmd_o equal to the cmd_i that was sampled, and busy_o high. host_trig_i has no effect while busy.
- R3: One cycle after tx_done_i is sampled, rx_arm_o is high and rx_frames_o carries the expected reply count. For codes 0..7 the count is 2+cmd[1:0]. For codes 8..11 it is 2. For codes 12..31 it is 3.
- R4: tx_mdf_o gives the number of memory frames to send. It is 0 for codes 0..11. For codes 12..15 it is 2 when cmd[0]=1 and 0 otherwise. For codes 16..31 it is 2 when cmd[0]=1 and 1 otherwise.
- R5: If rx_done_i is sampled with rx_crc_ok_i=1, then on the next cycle done_o=1, busy_o=0 and status_o=2'b01. If rx_crc_ok_i=0, status_o=2'b10.
- R6: If rx_frm_err_i is sampled, or if no rx_done_i arrives within TMO_CYC cycles of the receiver being armed, the transaction ends with done_o=1 and status_o=2'b11.
- R7: Codes 8..11 are reset-class. Each is transmitted and received REP_N times in one transaction, and rep_cnt_o reads REP_N at completion. For every other code rep_cnt_o reads 1. Any error during the repetitions ends the transaction early.
- R8: In periodic mode (mode_periodic_i=1), a start event occurs every period_i+1 cycles, counted from the switch into periodic mode. An event starts a transaction whenever the block is idle.
- R9: A periodic event that occurs while busy increments ovr_cnt_o by one, saturating at its maximum, and does not start a transaction.
- R10: done_o stays high until clr_done_i is asserted or a new transaction starts. Clearing it leaves status_o unchanged.
- R11: tx_start_o and rx_arm_o are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_periodic_i | input | 1 | 1 = periodic trigger, 0 = host trigger |
| host_trig_i | input | 1 | Host start request |
| period_i | input | PER_W | Period compare value (period is value+1 cycles) |
| cmd_i | input | 5 | Command code |
| clr_done_i | input | 1 | Clear completion flag |
| tx_start_o | output | 1 | Start transmitter pulse |
| tx_cmd_o | output | 5 | Latched command for transmitter |
| tx_mdf_o | output | 2 | Memory frames to append |
| tx_done_i | input | 1 | Transmitter finished |
| rx_arm_o | output | 1 | Arm receiver pulse |
| rx_frames_o | output | 4 | Expected reply frame count |
| rx_done_i | input | 1 | Receiver got all frames |
| rx_crc_ok_i | input | 1 | CRC result, valid with rx_done_i |
| rx_frm_err_i | input | 1 | Receiver framing error |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Completion flag |
| status_o | output | 2 | 00 none, 01 ok, 10 CRC bad, 11 fault |
| rep_cnt_o | output | $clog2(REP_N+1) | Transmissions done in current transaction |
| ovr_cnt_o | output | OVR_W | Periodic overrun count |

## Verification
The bench builds the block with PER_W=8, TMO_CYC=20 and REP_N=8. The short timeout makes it practical to wait for a silent receiver to run out of time, and the narrow period field lets several periodic events, including overruns while a transaction is stalled, fit into a short run. Keeping the full repetition count of 8 means complete reset-class bursts are covered, both those that finish and those cut short by a CRC or framing error.

// File: rtl/enc_txn_pkg.sv
package enc_txn_pkg;
  localparam int CMD_W = 5;
  localparam int FRM_W = 4;
  localparam int MDF_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TX_GO, ST_TX_WAIT, ST_RX_GO, ST_RX_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    STS_NONE = 2'b00, STS_OK = 2'b01, STS_CRC_BAD = 2'b10, STS_FAULT = 2'b11
  } txn_status_e;

  typedef struct packed {
    logic [FRM_W-1:0] frames;
    logic [MDF_W-1:0] mdf;
    logic             rep_cls;
  } cmd_info_t;
endpackage

// File: rtl/enc_cmd_lookup.sv
module enc_cmd_lookup
  import enc_txn_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_info_t        info_o
);
  always_comb begin
    info_o = '0;
    if (cmd_i[4]) begin
      // memory access: address frame, plus data frame on writes
      info_o.frames = FRM_W'(3);
      info_o.mdf    = cmd_i[0] ? MDF_W'(2) : MDF_W'(1);
    end else begin
      unique case (cmd_i[3:2])
        2'b00, 2'b01: info_o.frames = FRM_W'(2) + FRM_W'(cmd_i[1:0]);
        2'b10: begin
          info_o.frames  = FRM_W'(2);
          info_o.rep_cls = 1'b1;
        end
        default: begin
          info_o.frames = FRM_W'(3);
          info_o.mdf    = cmd_i[0] ? MDF_W'(2) : MDF_W'(0);
        end
      endcase
    end
  end
endmodule

// File: rtl/enc_trig_unit.sv
module enc_trig_unit #(
  parameter int PER_W = 16,
  parameter int OVR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_periodic_i,
  input  logic             host_trig_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic [OVR_W-1:0] ovr_cnt_o
);
  logic [PER_W-1:0] per_q;
  logic [OVR_W-1:0] ovr_q;
  logic             per_evt;

  assign per_evt = mode_periodic_i && (per_q >= period_i);
  assign start_o = !busy_i && (mode_periodic_i ? per_evt : host_trig_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      ovr_q <= '0;
    end else begin
      if (!mode_periodic_i || per_evt) per_q <= '0;
      else                             per_q <= per_q + 1'b1;
      if (per_evt && busy_i && (ovr_q != '1)) ovr_q <= ovr_q + 1'b1;
    end
  end

  assign ovr_cnt_o = ovr_q;
endmodule

// File: rtl/enc_seq_fsm.sv
module enc_seq_fsm
  import enc_txn_pkg::*;
#(
  parameter int REP_N   = 8,
  parameter int TMO_CYC = 256,
  localparam int REP_W  = $clog2(REP_N + 1),
  localparam int TMO_W  = $clog2(TMO_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             clr_done_i,
  input  cmd_info_t        info_i,
  input  logic             tx_done_i,
  input  logic             rx_done_i,
  input  logic             rx_crc_ok_i,
  input  logic             rx_frm_err_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             tx_start_o,
  output logic             rx_arm_o,
  output logic             busy_o,
  output logic             done_o,
  output txn_status_e      status_o,
  output logic [REP_W-1:0] rep_cnt_o
);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REP_N);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);

  seq_state_e       state_q;
  txn_status_e      status_q;
  logic [CMD_W-1:0] cmd_q;
  logic [REP_W-1:0] rep_q;
  logic [TMO_W-1:0] tmo_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      status_q <= STS_NONE;
      cmd_q    <= '0;
      rep_q    <= '0;
      tmo_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cmd_q    <= cmd_i;
            rep_q    <= '0;
            done_q   <= 1'b0;
            status_q <= STS_NONE;
            state_q  <= ST_TX_GO;
          end else if (clr_done_i) begin
            done_q <= 1'b0;
          end
        end
        ST_TX_GO: begin
          rep_q   <= rep_q + 1'b1;
          state_q <= ST_TX_WAIT;
        end
        ST_TX_WAIT: if (tx_done_i) state_q <= ST_RX_GO;
        ST_RX_GO: begin
          tmo_q   <= '0;
          state_q <= ST_RX_WAIT;
        end
        ST_RX_WAIT: begin
          if (rx_frm_err_i) begin
            status_q <= STS_FAULT;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (rx_done_i) begin
            if (!rx_crc_ok_i) begin
              status_q <= STS_CRC_BAD;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (info_i.rep_cls && (rep_q != REP_LAST)) begin
              state_q <= ST_TX_GO;
            end else begin
              status_q <= STS_OK;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end
          end else if (tmo_q == TMO_LAST) begin
            status_q <= STS_FAULT;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o      = cmd_q;
  assign tx_start_o = (state_q == ST_TX_GO);
  assign rx_arm_o   = (state_q == ST_RX_GO);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign status_o   = status_q;
  assign rep_cnt_o  = rep_q;
endmodule

// File: rtl/enc_txn_seq.sv
module enc_txn_seq
  import enc_txn_pkg::*;
#(
  parameter int PER_W   = 16,
  parameter int OVR_W   = 8,
  parameter int REP_N   = 8,
  parameter int TMO_CYC = 256
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       mode_periodic_i,
  input  logic                       host_trig_i,
  input  logic [PER_W-1:0]           period_i,
  input  logic [CMD_W-1:0]           cmd_i,
  input  logic                       clr_done_i,
  output logic                       tx_start_o,
  output logic [CMD_W-1:0]           tx_cmd_o,
  output logic [MDF_W-1:0]           tx_mdf_o,
  input  logic                       tx_done_i,
  output logic                       rx_arm_o,
  output logic [FRM_W-1:0]           rx_frames_o,
  input  logic                       rx_done_i,
  input  logic                       rx_crc_ok_i,
  input  logic                       rx_frm_err_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [1:0]                 status_o,
  output logic [$clog2(REP_N+1)-1:0] rep_cnt_o,
  output logic [OVR_W-1:0]           ovr_cnt_o
);
  logic        start;
  cmd_info_t   info;
  txn_status_e status;

  enc_trig_unit #(.PER_W(PER_W), .OVR_W(OVR_W)) u_trig (
    .clk_i, .rst_ni, .mode_periodic_i, .host_trig_i, .period_i,
    .busy_i(busy_o), .start_o(start), .ovr_cnt_o
  );

  enc_cmd_lookup u_lookup (.cmd_i(tx_cmd_o), .info_o(info));

  enc_seq_fsm #(.REP_N(REP_N), .TMO_CYC(TMO_CYC)) u_fsm (
    .clk_i, .rst_ni, .start_i(start), .cmd_i, .clr_done_i, .info_i(info),
    .tx_done_i, .rx_done_i, .rx_crc_ok_i, .rx_frm_err_i,
    .cmd_o(tx_cmd_o), .tx_start_o, .rx_arm_o, .busy_o, .done_o,
    .status_o(status), .rep_cnt_o
  );

  assign status_o    = status;
  assign tx_mdf_o    = info.mdf;
  assign rx_frames_o = info.frames;
endmodule

// File: rtl/enc_txn_seq_chk.sv
module enc_txn_seq_chk #(
  parameter int OVR_W = 8,
  parameter int REP_N = 8,
  localparam int REP_W = $clog2(REP_N + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_done_i,
  input logic             tx_start_o,
  input logic             rx_arm_o,
  input logic [3:0]       rx_frames_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [REP_W-1:0] rep_cnt_o,
  input logic [OVR_W-1:0] ovr_cnt_o
);
  assert_tx_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);
  assert_arm_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_arm_o |=> !rx_arm_o);
  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> busy_o);
  assert_frames_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_arm_o |-> (rx_frames_o >= 4'd2 && rx_frames_o <= 4'd5));
  assert_done_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
  assert_rep_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_cnt_o <= REP_W'(REP_N));
  assert_ovr_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ovr_cnt_o) |-> ($past(busy_o) && ovr_cnt_o == $past(ovr_cnt_o) + 1'b1));
  assert_done_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));
  assert_done_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_done_i) |=> (done_o || tx_start_o));
endmodule

bind enc_txn_seq enc_txn_seq_chk #(.OVR_W(OVR_W), .REP_N(REP_N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_done_i(clr_done_i),
  .tx_start_o(tx_start_o), .rx_arm_o(rx_arm_o), .rx_frames_o(rx_frames_o),
  .busy_o(busy_o), .done_o(done_o), .rep_cnt_o(rep_cnt_o), .ovr_cnt_o(ovr_cnt_o)
);

// File: tb/test_enc_txn_seq.sv
`timescale 1ns/1ps
module test_enc_txn_seq;
  localparam int PER_W = 8;
  localparam int OVR_W = 8;
  localparam int REP_N = 8;
  localparam int TMO   = 20;
  localparam int P     = 9;

  logic clk = 0, rst_n = 0;
  logic mode = 0, host_trig = 0, clr_done = 0;
  logic [PER_W-1:0] period = '0;
  logic [4:0] cmd = '0;
  logic tx_done = 0, rx_done = 0, rx_crc_ok = 0, rx_frm_err = 0;
  logic tx_start, rx_arm, busy, done;
  logic [4:0] tx_cmd;
  logic [1:0] tx_mdf, status;
  logic [3:0] rx_frames, rep_cnt;
  logic [OVR_W-1:0] ovr_cnt;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  enc_txn_seq #(.PER_W(PER_W), .OVR_W(OVR_W), .REP_N(REP_N), .TMO_CYC(TMO)) i_enc_txn_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_periodic_i(mode), .host_trig_i(host_trig),
    .period_i(period), .cmd_i(cmd), .clr_done_i(clr_done),
    .tx_start_o(tx_start), .tx_cmd_o(tx_cmd), .tx_mdf_o(tx_mdf), .tx_done_i(tx_done),
    .rx_arm_o(rx_arm), .rx_frames_o(rx_frames), .rx_done_i(rx_done),
    .rx_crc_ok_i(rx_crc_ok), .rx_frm_err_i(rx_frm_err),
    .busy_o(busy), .done_o(done), .status_o(status), .rep_cnt_o(rep_cnt), .ovr_cnt_o(ovr_cnt)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_frames(input logic [4:0] c);
    if (c < 8)  return 2 + int'(c[1:0]);
    if (c < 12) return 2;
    return 3;
  endfunction

  function automatic int exp_mdf(input logic [4:0] c);
    if (c < 12) return 0;
    if (c < 16) return c[0] ? 2 : 0;
    return c[0] ? 2 : 1;
  endfunction

  function automatic bit is_rst(input logic [4:0] c);
    return (c >= 8 && c < 12);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // err: 0 none, 1 framing error, 2 timeout
  task automatic host_txn(input logic [4:0] c, input bit crc_ok, input int err, input bit retrig);
    int reps = is_rst(c) ? REP_N : 1;
    @(negedge clk); cmd = c; host_trig = 1;
    @(negedge clk); host_trig = 0;
    for (int r = 0; r < reps; r++) begin
      chk(tx_start == 1, "R2 tx_start", int'(tx_start), 1);
      chk(tx_cmd == c, "R2 tx_cmd", int'(tx_cmd), int'(c));
      chk(busy == 1, "R2 busy", int'(busy), 1);
      chk(int'(tx_mdf) == exp_mdf(c), "R4 mdf", int'(tx_mdf), exp_mdf(c));
      if (retrig && r == 0) begin
        host_trig = 1;
        @(negedge clk); host_trig = 0;
        chk(tx_start == 0, "R2 retrig ignored", int'(tx_start), 0);
      end
      repeat (1 + $urandom_range(0, 3)) @(negedge clk);
      tx_done = 1;
      @(negedge clk); tx_done = 0;
      chk(rx_arm == 1, "R3 rx_arm", int'(rx_arm), 1);
      chk(int'(rx_frames) == exp_frames(c), "R3 frames", int'(rx_frames), exp_frames(c));
      @(negedge clk);
      chk(rx_arm == 0, "R11 arm pulse", int'(rx_arm), 0);
      if (err == 2) begin
        repeat (TMO - 1) @(negedge clk);
        chk(busy == 1 && done == 0, "R6 before timeout", int'(done), 0);
        @(negedge clk);
        chk(done == 1 && busy == 0, "R6 timeout done", int'(done), 1);
        chk(status == 2'b11, "R6 timeout status", int'(status), 3);
        return;
      end
      repeat ($urandom_range(0, 3)) @(negedge clk);
      if (err == 1) rx_frm_err = 1;
      else begin rx_done = 1; rx_crc_ok = crc_ok; end
      @(negedge clk); rx_frm_err = 0; rx_done = 0; rx_crc_ok = 0;
      if (err == 1) begin
        chk(done == 1 && status == 2'b11, "R6 frame err", int'(status), 3);
        return;
      end
      if (!crc_ok) begin
        chk(done == 1 && busy == 0, "R5 crc done", int'(done), 1);
        chk(status == 2'b10, "R5 crc bad status", int'(status), 2);
        chk(int'(rep_cnt) == r + 1, "R7 early stop", int'(rep_cnt), r + 1);
        return;
      end
    end
    chk(done == 1 && busy == 0, "R5 done", int'(done), 1);
    chk(status == 2'b01, "R5 ok status", int'(status), 1);
    chk(int'(rep_cnt) == reps, "R7 rep count", int'(rep_cnt), reps);
  endtask

  task automatic wait_start(output int t);
    t = -1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tx_start) begin t = cyc; break; end
    end
  endtask

  task automatic quick_reply();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    @(negedge clk); rx_done = 1; rx_crc_ok = 1;
    @(negedge clk); rx_done = 0; rx_crc_ok = 0;
    chk(done == 1 && status == 2'b01, "R8 periodic txn ok", int'(status), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int t0, t1, t2;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 flags", int'({busy, done}), 0);
    chk(status == 0 && rep_cnt == 0 && ovr_cnt == 0, "R1 status", int'(status), 0);
    chk(tx_start == 0 && rx_arm == 0, "R1 pulses", int'({tx_start, rx_arm}), 0);
    rst_n = 1;
    @(negedge clk);

    // directed corners
    host_txn(5'd3, 1, 0, 1);
    host_txn(5'd9, 1, 0, 0);
    host_txn(5'd8, 0, 0, 0);
    host_txn(5'd17, 1, 1, 0);
    host_txn(5'd14, 1, 2, 0);
    host_txn(5'd13, 1, 0, 0);
    host_txn(5'd16, 1, 0, 0);

    // R10 hold and clear
    repeat (5) @(negedge clk);
    chk(done == 1, "R10 hold", int'(done), 1);
    clr_done = 1;
    @(negedge clk); clr_done = 0;
    chk(done == 0, "R10 clear", int'(done), 0);
    chk(status == 2'b01, "R10 status kept", int'(status), 1);

    // random
    for (int k = 0; k < 40; k++) begin
      logic [4:0] c = 5'($urandom_range(0, 31));
      bit ok = ($urandom_range(0, 99) < 85);
      int e = ($urandom_range(0, 99) < 10) ? 1 : 0;
      host_txn(c, ok, e, 0);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    // periodic mode
    period = PER_W'(P);
    @(negedge clk); mode = 1;
    wait_start(t0);
    chk(t0 >= 0, "R8 first start", t0, 0);
    repeat (3 * (P + 1)) @(negedge clk);
    chk(int'(ovr_cnt) == 3, "R9 overruns", int'(ovr_cnt), 3);
    chk(busy == 1 && tx_start == 0, "R9 not started", int'(tx_start), 0);
    quick_reply();
    wait_start(t1);
    chk(t1 - t0 == 4 * (P + 1), "R8 spacing after stall", t1 - t0, 4 * (P + 1));
    chk(done == 0, "R10 start clears", int'(done), 0);
    quick_reply();
    wait_start(t2);
    chk(t2 - t1 == P + 1, "R8 period", t2 - t1, P + 1);
    chk(int'(ovr_cnt) == 3, "R9 no extra overrun", int'(ovr_cnt), 3);
    quick_reply();
    mode = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    summary();
    $finish;
  end
endmodule